// File: doc/BRIEF.md
# Microsecond Limit Counter Timer

This block is a small bank of memory-mapped interval timers: one timer per processor plus one shared system timer. Every timer holds a counter that advances once per microsecond and a limit value. When the advanced count would reach the limit, the counter goes back to 1 and the timer raises its interrupt request. The request stays up until software acknowledges it. The shared timer drives the level-10 system request. Each processor timer drives the level-14 request of its own processor.

Software programs a period of P microseconds by writing (P+1) into the value field, which sits above a 10-bit shift in the word. Reading the limit word acknowledges the request. A second alias of the limit returns the same value and leaves the request alone. Writing 0 to a limit stops that timer's requests. The microsecond tick comes from the system clock through a parameterised prescaler. Each processor also has a one-bit user start/stop word, and the shared block has a configuration word. Both are plain storage.

Top module: `usec_limit_timer`

## Requirements
- R1: After reset, all limits, counts, the user start/stop bits and the configuration bits read 0, and every interrupt output is low.
- R2: Word addresses: processor c uses 4c+0 for the limit, 4c+1 for the count, 4c+2 for the non-clearing limit alias and 4c+3 for the user start/stop bit (bit 0). The shared timer uses 4·NCPU+0 for the limit, +1 for the count, +2 for the alias, +3 for a reserved word that reads 0, and +4 for the configuration word.
- R3: Limit and count values occupy bits 31..10 of the word. Bits 9..0 read as 0 and are ignored on write.
- R4: The counter advances once every CLK_PER_US clocks. With a limit L ≥ 2, consecutive request assertions are (L−1)·CLK_PER_US clocks apart.
- R5: On the tick where the advanced count would equal the limit, the count becomes 1 and the request is set in the same clock.
- R6: A read at the limit address clears the request on the next clock. A read at the alias returns the same value and leaves the request set.
- R7: If an acknowledging read falls in the same clock as a new expiry, the request stays set.
- R8: A write to a limit address loads the new value, sets the count to 0 and clears the pending request on the next clock.
- R9: While a limit is 0, that timer never raises its request.
- R10: The shared timer drives only irq_l10, and processor c's timer drives only irq_l14[c].
- R11: The user start/stop bits and the NCPU-bit configuration word read back what was written. Writes to a count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe, qualified by sel |
| rd | input | 1 | Read strobe, qualified by sel (drives side effects) |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_l10 | output | 1 | Shared timer request |
| irq_l14 | output | NCPU | Per-processor timer requests |

## Verification
A counter or prescaler that is out of step shows up at the request outputs within one period: the spacing between two assertions is measured in clocks and compared with (L−1)·CLK_PER_US. A lost acknowledge or a lost set appears one clock after the read, because the request output is sampled right after that edge. Count values are sampled in the clock of the expiry and in the clock after a limit write, where they must be exactly 1 and 0. Any stale counter or wrong restart value is therefore visible immediately, not after many periods.

// File: rtl/usec_limit_timer.sv
module usec_limit_timer #(
  parameter int NCPU       = 2,
  parameter int CLK_PER_US = 125,
  localparam int AW = $clog2(4 * NCPU + 5)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq_l10,
  output logic [NCPU-1:0] irq_l14
);
  localparam int NT    = NCPU + 1;
  localparam int VW    = 22;
  localparam int PW    = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int GBASE = 4 * NCPU;

  logic [PW-1:0]   pre;
  logic            tick;
  logic [VW-1:0]   lim [NT];
  logic [VW-1:0]   cnt [NT];
  logic [NT-1:0]   irq, hit, wr_lim, rd_lim, rd_nc;
  logic [NCPU-1:0] run;
  logic [NCPU-1:0] cfg;
  logic            unused_bits;

  assign unused_bits = ^wdata[9:0];
  assign tick = (pre == PW'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam int LA = (t < NCPU) ? 4 * t : GBASE;
    logic [VW-1:0] nxt;

    assign wr_lim[t] = sel & wr & (addr == AW'(LA));
    assign rd_lim[t] = sel & rd & (addr == AW'(LA));
    assign rd_nc[t]  = sel & rd & (addr == AW'(LA + 2));
    assign nxt       = cnt[t] + 1'b1;
    assign hit[t]    = tick & (lim[t] != '0) & (nxt == lim[t]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lim[t] <= '0;
        cnt[t] <= '0;
        irq[t] <= 1'b0;
      end else if (wr_lim[t]) begin
        lim[t] <= wdata[31:10];
        cnt[t] <= '0;
        irq[t] <= 1'b0;
      end else begin
        if (hit[t])    cnt[t] <= VW'(1);
        else if (tick) cnt[t] <= nxt;
        irq[t] <= hit[t] | (irq[t] & ~rd_lim[t]);
      end

    // R8
    lim_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lim[t] |=> (cnt[t] == '0) && !irq[t]);
    // R9
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lim[t] == '0) |-> !irq[t]);
    // R6
    noclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[t] && rd_nc[t] && !wr_lim[t] |=> irq[t]);
    // R6
    ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lim[t] && !wr_lim[t] && !hit[t] |=> !irq[t]);
    // R7
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[t] && !wr_lim[t] |=> irq[t] && (cnt[t] == VW'(1)));
    // R4
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[t]) |-> $past(tick));
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_run
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) run[c] <= 1'b0;
      else if (sel && wr && addr == AW'(4 * c + 3)) run[c] <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= '0;
    else if (sel && wr && addr == AW'(GBASE + 4)) cfg <= wdata[NCPU-1:0];

  always_comb begin
    rdata = '0;
    for (int t = 0; t < NT; t++) begin
      if (addr == AW'((t < NCPU) ? 4 * t : GBASE))     rdata = {lim[t], 10'b0};
      if (addr == AW'((t < NCPU) ? 4 * t + 1 : GBASE + 1)) rdata = {cnt[t], 10'b0};
      if (addr == AW'((t < NCPU) ? 4 * t + 2 : GBASE + 2)) rdata = {lim[t], 10'b0};
    end
    for (int c = 0; c < NCPU; c++)
      if (addr == AW'(4 * c + 3)) rdata = {31'b0, run[c]};
    if (addr == AW'(GBASE + 4)) rdata = {{(32 - NCPU){1'b0}}, cfg};
  end

  assign irq_l10 = irq[NCPU];
  assign irq_l14 = irq[NCPU-1:0];

  // R10
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_l10) |-> $past(hit[NCPU]));
endmodule

// File: tb/usec_limit_timer_tb.sv
`timescale 1ns/1ps
module usec_limit_timer_tb;
  localparam int NCPU = 2;
  localparam int CPU  = 4;
  localparam int AW   = $clog2(4 * NCPU + 5);

  logic clk = 0, rst_n = 0, sel = 0, wr = 0, rd = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_l10;
  logic [NCPU-1:0] irq_l14;
  int checks = 0, failures = 0;
  int cyc = 0;
  int r1, r2;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usec_limit_timer #(.NCPU(NCPU), .CLK_PER_US(CPU)) u_dut (
    .clk, .rst_n, .sel, .wr, .rd, .addr, .wdata, .rdata, .irq_l10, .irq_l14);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    sel = 1; wr = 1; addr = AW'(a); wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    sel = 1; rd = 1; addr = AW'(a);
    #2 d = rdata;
    @(posedge clk); @(negedge clk);
    sel = 0; rd = 0;
  endtask

  task automatic wait_rise(input int which, output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ((which == NCPU ? irq_l10 : irq_l14[which]) == 1'b1) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4 * NCPU + 5; a++) begin
      if (a == 1 || a == 5 || a == 9) continue;
      rd_reg(a, d);
      chk(d == 0, "R1 reset read", d, 0);
    end
    chk({irq_l10, irq_l14} == 0, "R1 reset irqs", {irq_l10, irq_l14}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr_reg(4, 32'hFFFF_FFFF);
    rd_reg(4, d); chk(d == 32'hFFFF_FC00, "R3 limit field", d, 32'hFFFF_FC00);
    rd_reg(6, d); chk(d == 32'hFFFF_FC00, "R2 alias of cpu1 limit", d, 32'hFFFF_FC00);
    rd_reg(8, d); chk(d == 0, "R2 shared limit untouched", d, 0);
    rd_reg(0, d); chk(d == 0, "R2 cpu0 limit untouched", d, 0);
    wr_reg(4, 0);
  endtask

  task automatic t_storage;
    logic [31:0] d;
    wr_reg(3, 32'h1); wr_reg(12, 32'h3); wr_reg(11, 32'hFFFF_FFFF);
    rd_reg(3, d);  chk(d == 1, "R11 cpu0 run bit", d, 1);
    rd_reg(7, d);  chk(d == 0, "R11 cpu1 run bit", d, 0);
    rd_reg(12, d); chk(d == 3, "R11 config word", d, 3);
    rd_reg(11, d); chk(d == 0, "R2 reserved reads 0", d, 0);
    wr_reg(0, 0);
    wr_reg(1, 32'hFFFF_FC00);
    rd_reg(1, d); chk(d <= 32'h800, "R11 count write ignored", d, 32'h800);
  endtask

  task automatic t_period;
    logic [31:0] d;
    wr_reg(0, 5 << 10);
    rd_reg(1, d); chk(d == 0, "R8 count zero after write", d, 0);
    wait_rise(0, r1);
    chk(r1 >= 0, "R4 first expiry", r1, 0);
    chk(irq_l10 == 0 && irq_l14[1] == 0, "R10 only cpu0 request", {irq_l10, irq_l14}, 1);
    rd_reg(1, d); chk(d == 1 << 10, "R5 count restarts at 1", d, 1 << 10);
    rd_reg(2, d); chk(d == 5 << 10, "R6 alias value", d, 5 << 10);
    chk(irq_l14[0] == 1, "R6 alias keeps request", irq_l14[0], 1);
    rd_reg(0, d); chk(irq_l14[0] == 0, "R6 limit read acks", irq_l14[0], 0);
    wait_rise(0, r2);
    chk(r2 - r1 == 4 * CPU, "R4 period in clocks", r2 - r1, 4 * CPU);
  endtask

  task automatic t_setwins;
    logic [31:0] d;
    while (cyc != r2 + 4 * CPU - 1) @(negedge clk);
    rd_reg(0, d);
    chk(irq_l14[0] == 1, "R7 expiry wins over ack", irq_l14[0], 1);
    rd_reg(0, d);
    chk(irq_l14[0] == 0, "R7 later ack clears", irq_l14[0], 0);
  endtask

  task automatic t_disable;
    int seen = 0;
    wr_reg(0, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (irq_l14[0]) seen++;
    end
    chk(seen == 0, "R9 zero limit silent", seen, 0);
  endtask

  task automatic t_global;
    logic [31:0] d;
    int at;
    wr_reg(8, 3 << 10);
    wait_rise(NCPU, at);
    chk(at >= 0 && irq_l14 == 0, "R10 shared drives only l10", {irq_l10, irq_l14}, 4);
    rd_reg(10, d); chk(d == 3 << 10, "R2 shared alias", d, 3 << 10);
    rd_reg(8, d);  chk(irq_l10 == 0, "R6 shared ack", irq_l10, 0);
    wr_reg(8, 0);
    wr_reg(4, 3 << 10);
    wait_rise(1, at);
    chk(at >= 0 && irq_l10 == 0 && irq_l14[0] == 0, "R10 cpu1 drives only its line", {irq_l10, irq_l14}, 2);
  endtask

  task automatic t_write_clears;
    logic [31:0] d;
    wr_reg(4, 3 << 10);
    chk(irq_l14[1] == 0, "R8 write clears request", irq_l14[1], 0);
    rd_reg(5, d); chk(d == 0, "R8 write zeroes count", d, 0);
    wr_reg(4, 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_storage();
    t_period();
    t_setwins();
    t_disable();
    t_global();
    t_write_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule